// File: doc/BRIEF.md
# Data Bus Line Self-Test Engine

This block is a hardware self-test engine for a 64-bit memory data bus. It looks for data lines that are shorted together or left open. After a one-cycle start pulse it owns a simple memory port: a request strobe, a write enable, a word address and write data going out, and read data with a valid strobe coming back. For every entry of a fixed pattern list it writes the pattern to a target word. It then writes a fixed decoy word to the next word address, so that a floating bus cannot keep the pattern charged and fake a pass. It then reads the target once and compares the result with the pattern.

A mismatch never stops the run. All patterns are applied, a sticky fail flag records whether any of them failed, and the first failure is held for inspection: pattern index, target address, expected word and the word actually read. An error-injection input lets the failure path be exercised against memory that works.

Top module: `data_bus_tester`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `fail`, `mem_req`, `mem_we` and every error-report output are zero.
- R2: A start pulse seen while idle latches `base_addr` and begins a run. The first pattern write appears on the port in the following cycle. A start pulse seen while busy has no effect on the access sequence or the run length.
- R3: Twelve patterns are applied in this order. Patterns 0 to 5 set data bit i exactly when bit k of the index i is 1, with k equal to the pattern number (0xAAAA..., 0xCCCC..., 0xF0F0..., 0xFF00FF00..., 0xFFFF0000FFFF0000, 0xFFFFFFFF00000000). Pattern p for p from 6 to 11 is the bitwise inverse of pattern 11-p.
- R4: Each pattern takes three requests, one per cycle and back to back: a write of the pattern to the base address, a write of 0x0123456789ABCDEF to the base address plus one (modulo the address width), then a read of the base address.
- R5: After the read request the engine issues nothing until `mem_rvalid` arrives. Any read latency of one cycle or more is accepted, so one pattern lasts 4 plus latency cycles.
- R6: Each target is read exactly once per pattern, and the single captured word is used both for the compare and for the error report.
- R7: A mismatch does not shorten the run: all twelve patterns are always applied.
- R8: `fail` rises after a mismatched compare and stays high until the next accepted start, which clears it.
- R9: On the first mismatch of a run, `err_idx`, `err_addr`, `err_expect` and `err_read` capture the pattern number, the target address, the pattern and the word read. Later mismatches in the same run leave them unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the twelfth compare, and `busy` is low from that cycle on. `busy` is high from the first write until then.
- R11: While `inject_err` is high, bit 15 of the captured read word is inverted before the compare and before the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| base_addr | input | 16 | Word address of the target |
| inject_err | input | 1 | Invert bit 15 of captured read data |
| mem_req | output | 1 | Memory access strobe, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| err_idx | output | 4 | Pattern number of first mismatch |
| err_addr | output | 16 | Target address of first mismatch |
| err_expect | output | 64 | Expected word of first mismatch |
| err_read | output | 64 | Captured word of first mismatch |

## Verification
The bench puts a memory model behind the port that can run with good storage, with one data lane stuck low, or as a floating bus that returns the last value driven. A design that skipped the decoy write would pass the floating case. A design that stopped at the first error, or let a later mismatch overwrite the report, would show the wrong run length or the wrong pattern number for the stuck lane. The bench also runs with a long read latency and with the base at the top of the address space, where a design that did not wait for the valid strobe, or that placed the decoy at the wrong address, breaks the expected access sequence. A second start sent in the middle of a run must leave that sequence and the run time unchanged.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // State names the access currently on the memory port.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WPAT  = 2'd1,
    ST_WDEC  = 2'd2,
    ST_WAIT  = 2'd3
  } dbt_state_t;
endpackage

// File: rtl/dbt_pattern_gen.sv
// Computes the walking-stride pattern list: NBASE base words, then their
// inverses in reverse order.
module dbt_pattern_gen #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  sel,
  output logic [DATA_W-1:0] pat
);
  localparam int NBASE = $clog2(DATA_W);
  localparam int NPAT  = 2 * NBASE;

  logic [NBASE-1:0][DATA_W-1:0] base_pat;

  for (genvar k = 0; k < NBASE; k++) begin : g_stride
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign base_pat[k][i] = ((i >> k) & 1) != 0;
    end
  end

  always_comb begin
    pat = '0;
    for (int k = 0; k < NBASE; k++) begin
      if (sel == IDX_W'(k))            pat = base_pat[k];
      if (sel == IDX_W'(NPAT - 1 - k)) pat = ~base_pat[k];
    end
  end
endmodule

// File: rtl/dbt_ctrl.sv
module dbt_ctrl
  import dbt_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 64,
  parameter int                IDX_W  = 4,
  parameter int                NPAT   = 12,
  parameter logic [DATA_W-1:0] DECOY  = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] pat_next,
  output logic [IDX_W-1:0]  pat_sel,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              accept,
  output logic              clear,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  dbt_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              last;

  assign clear    = (state_q == ST_IDLE) && start;
  assign accept   = (state_q == ST_WAIT) && mem_rvalid;
  assign last     = (idx_q == IDX_W'(NPAT - 1));
  assign pat_sel  = clear ? '0 : idx_q + 1'b1;
  assign cur_idx  = idx_q;
  assign tgt_addr = base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      base_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          base_q    <= base_addr;
          idx_q     <= '0;
          busy      <= 1'b1;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= base_addr;
          mem_wdata <= pat_next;
          state_q   <= ST_WPAT;
        end
        ST_WPAT: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= base_q + 1'b1;
          mem_wdata <= DECOY;
          state_q   <= ST_WDEC;
        end
        ST_WDEC: begin
          mem_req  <= 1'b1;
          mem_addr <= base_q;
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (mem_rvalid) begin
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q     <= idx_q + 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base_q;
            mem_wdata <= pat_next;
            state_q   <= ST_WPAT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbt_compare.sv
// Captures the single readback, compares it and holds the first failure.
module dbt_compare #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 4,
  parameter int INJ_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept,
  input  logic              inject_err,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] expect_pat,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  output logic              fail,
  output logic [IDX_W-1:0]  err_idx,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_expect,
  output logic [DATA_W-1:0] err_read
);
  localparam logic [DATA_W-1:0] INJ_MASK = DATA_W'(1) << INJ_BIT;

  logic [DATA_W-1:0] captured;
  logic              mismatch;

  assign captured = inject_err ? (rdata ^ INJ_MASK) : rdata;
  assign mismatch = accept && (captured != expect_pat);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail       <= 1'b0;
      err_idx    <= '0;
      err_addr   <= '0;
      err_expect <= '0;
      err_read   <= '0;
    end else if (mismatch && !fail) begin
      fail       <= 1'b1;
      err_idx    <= idx;
      err_addr   <= addr;
      err_expect <= expect_pat;
      err_read   <= captured;
    end
  end
endmodule

// File: rtl/data_bus_tester.sv
module data_bus_tester #(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 64,
  parameter int                INJ_BIT = 15,
  parameter logic [DATA_W-1:0] DECOY   = 64'h0123_4567_89AB_CDEF
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [ADDR_W-1:0]                 base_addr,
  input  logic                              inject_err,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  input  logic [DATA_W-1:0]                 mem_rdata,
  input  logic                              mem_rvalid,
  output logic                              busy,
  output logic                              done,
  output logic                              fail,
  output logic [$clog2(2*$clog2(DATA_W))-1:0] err_idx,
  output logic [ADDR_W-1:0]                 err_addr,
  output logic [DATA_W-1:0]                 err_expect,
  output logic [DATA_W-1:0]                 err_read
);
  localparam int NPAT  = 2 * $clog2(DATA_W);
  localparam int IDX_W = $clog2(NPAT);

  logic [IDX_W-1:0]  pat_sel, cur_idx;
  logic [DATA_W-1:0] pat_next, pat_cur;
  logic [ADDR_W-1:0] tgt_addr;
  logic              accept, clear;

  dbt_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat_issue (
    .sel(pat_sel), .pat(pat_next));

  dbt_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat_check (
    .sel(cur_idx), .pat(pat_cur));

  dbt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .NPAT(NPAT), .DECOY(DECOY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .mem_rvalid(mem_rvalid), .pat_next(pat_next), .pat_sel(pat_sel),
    .cur_idx(cur_idx), .tgt_addr(tgt_addr), .accept(accept), .clear(clear),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done));

  dbt_compare #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .INJ_BIT(INJ_BIT)
  ) u_cmp (
    .clk(clk), .rst(rst), .clear(clear), .accept(accept),
    .inject_err(inject_err), .rdata(mem_rdata), .expect_pat(pat_cur),
    .idx(cur_idx), .addr(tgt_addr), .fail(fail), .err_idx(err_idx),
    .err_addr(err_addr), .err_expect(err_expect), .err_read(err_read));
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 64,
  parameter logic [DATA_W-1:0] DECOY  = 64'h0123_4567_89AB_CDEF
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy)) |=> fail); // R8
  AST_DECOY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && $past(mem_req && mem_we))
      |-> (mem_wdata == DECOY && mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R4
  AST_READ_AFTER_DECOY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> $past(mem_req && mem_we && mem_wdata == DECOY)); // R4
  AST_READ_TARGET: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> mem_addr == ADDR_W'($past(mem_addr) - 1'b1)); // R6
endmodule

bind data_bus_tester dbt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECOY(DECOY)
) u_dbt_checker (
  .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .fail(fail));

// File: tb/data_bus_tester_bench.sv
`timescale 1ns/1ps
module data_bus_tester_bench;
  localparam logic [63:0] DECOY = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic        inject_err = 1'b0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        busy, done, fail;
  logic [3:0]  err_idx;
  logic [15:0] err_addr;
  logic [63:0] err_expect, err_read;

  always #2 clk = ~clk;

  data_bus_tester u_data_bus_tester (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .inject_err(inject_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .fail(fail),
    .err_idx(err_idx), .err_addr(err_addr), .err_expect(err_expect),
    .err_read(err_read));

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3: pattern list written out from the requirement
  logic [63:0] pats [12] = '{
    64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
    64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
    64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

  // Memory model: 0 good, 1 lane 20 stuck low, 2 floating bus
  int          lat_cfg = 1;
  int          fault   = 0;
  logic [63:0] store [256];
  logic [63:0] last_w = '0;
  int          rd_cnt = 0;
  logic [7:0]  rd_a   = '0;

  always @(posedge clk) begin
    mem_rvalid <= (rd_cnt == 1);
    if (rd_cnt == 1)
      mem_rdata <= (fault == 2) ? last_w : store[rd_a];
    if (mem_req && mem_we) begin
      store[mem_addr[7:0]] <= (fault == 1) ? (mem_wdata & ~(64'd1 << 20)) : mem_wdata;
      last_w <= mem_wdata;
    end
    if (mem_req && !mem_we) begin
      rd_cnt <= lat_cfg;
      rd_a   <= mem_addr[7:0];
    end else if (rd_cnt > 0) begin
      rd_cnt <= rd_cnt - 1;
    end
  end

  // Reference model: busy/done from start and delivered read strobes
  bit m_busy = 0, m_done = 0;
  int m_reads = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_reads <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy && start) begin
        m_busy <= 1; m_reads <= 0;
      end else if (m_busy && mem_rvalid) begin
        m_reads <= m_reads + 1;
        if (m_reads == 11) begin m_busy <= 0; m_done <= 1; end
      end
    end
  end

  typedef struct { bit we; logic [15:0] a; logic [63:0] d; } acc_t;
  acc_t exp_q[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R10 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R10 done", 64'(done), 64'(m_done));
      if (mem_req) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected request", 64'(mem_addr), 64'hx);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, "R4 access kind", 64'(mem_we), 64'(e.we));
          chk(mem_addr == e.a, "R4 access address", 64'(mem_addr), 64'(e.a));
          if (e.we) chk(mem_wdata == e.d, "R3 write data", mem_wdata, e.d);
        end
      end
    end
  end

  task automatic run(input logic [15:0] b, input int lat, input int fm,
                     input bit inj, input bit second_start, output int ncyc);
    @(negedge clk);
    lat_cfg = lat; fault = fm; inject_err = inj; base_addr = b;
    for (int p = 0; p < 12; p++) begin
      exp_q.push_back('{1'b1, b, pats[p]});
      exp_q.push_back('{1'b1, 16'(b + 16'd1), DECOY});
      exp_q.push_back('{1'b0, b, 64'd0});
    end
    start = 1;
    ncyc = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      start = 0;
      if (second_start && n == 2) start = 1; // R2: ignored while busy
      ncyc++;
      if (done) break;
    end
    start = 0;
    chk(exp_q.size() == 0, "R7 all patterns applied", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  int cyc;
  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && mem_req == 0 && mem_we == 0,
        "R1 reset outputs", {busy, done, fail, mem_req}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && fail == 0 && mem_req == 0 && err_read == 0 && err_expect == 0,
        "R1 after reset", err_read, 64'd0);

    // good memory, latency 1
    run(16'h0010, 1, 0, 0, 0, cyc);
    chk(cyc == 12 * 5 + 1, "R5 run length lat1", 64'(cyc), 64'(12 * 5 + 1));
    chk(fail == 0, "R8 good memory passes", 64'(fail), 64'd0);

    // long latency, base at top of address space (decoy wraps to 0)
    run(16'hFFFF, 5, 0, 0, 1, cyc);
    chk(cyc == 12 * 9 + 1, "R5 R2 run length lat5 with extra start", 64'(cyc), 64'(12 * 9 + 1));
    chk(fail == 0, "R4 wrap passes", 64'(fail), 64'd0);

    // injection
    run(16'h0040, 2, 0, 1, 0, cyc);
    chk(fail == 1, "R11 inject sets fail", 64'(fail), 64'd1);
    chk(err_idx == 0, "R9 inject idx", 64'(err_idx), 64'd0);
    chk(err_read == (pats[0] ^ 64'h8000), "R11 R6 inject read", err_read, pats[0] ^ 64'h8000);
    chk(err_expect == pats[0], "R9 inject expect", err_expect, pats[0]);
    chk(err_addr == 16'h0040, "R9 inject addr", 64'(err_addr), 64'h40);
    inject_err = 0;

    // good run after failure clears sticky flag
    run(16'h0020, 1, 0, 0, 0, cyc);
    chk(fail == 0, "R8 start clears fail", 64'(fail), 64'd0);
    chk(err_read == 0, "R8 report cleared", err_read, 64'd0);

    // lane 20 stuck low: first pattern with bit 20 set is index 2
    run(16'h0033, 3, 1, 0, 0, cyc);
    chk(cyc == 12 * 7 + 1, "R7 run not stopped by error", 64'(cyc), 64'(12 * 7 + 1));
    chk(fail == 1, "R8 stuck lane fails", 64'(fail), 64'd1);
    chk(err_idx == 2, "R9 first failing pattern", 64'(err_idx), 64'd2);
    chk(err_read == (pats[2] & ~(64'd1 << 20)), "R9 stuck read", err_read,
        pats[2] & ~(64'd1 << 20));
    chk(err_expect == pats[2], "R9 stuck expect", err_expect, pats[2]);

    // floating bus: returns last driven value, the decoy
    run(16'h0005, 1, 2, 0, 0, cyc);
    chk(fail == 1, "R4 floating bus caught", 64'(fail), 64'd1);
    chk(err_idx == 0, "R9 floating idx", 64'(err_idx), 64'd0);
    chk(err_read == DECOY, "R6 floating read", err_read, DECOY);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule